// File: doc/BRIEF.md
# Contactless Frame Bit Encoder

This block turns a short byte frame, whose check bytes the caller has already appended, into a serial stream with one bit for each elementary time unit. The stream is framed for a 106 kbit/s Type B proximity link and feeds an external modulator over a valid/ready bit interface. A caller starts a frame with a one-cycle `start` that carries the byte count and the framing side. The block then pulls each byte through a valid/ready byte port, one byte per character.

The two framing sides share every part of the frame except its head and its tail. A frame is built as follows:

- a run of logic ones: 20 in tag mode, 40 in reader mode;
- a start-of-frame marker of 10 zeros and then 2 ones;
- one 10-bit character for each byte;
- an end-of-frame marker of 10 zeros;
- a run of trailing ones: 2 in tag mode, 32 in reader mode. The reader tail is long so that the last character is fully out before the link turns around.

A one-cycle `done` marks the end of the frame.

Top module: `frame_bit_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bitValid`, `byteReady` and `done` are all 0.
- R2: With `readerMode`=0 latched at start, the stream opens with exactly 20 bits of value 1.
- R3: With `readerMode`=1 latched at start, the stream opens with exactly 40 bits of value 1.
- R4: After the opening run, the stream carries 10 bits of value 0 and then 2 bits of value 1.
- R5: Each byte is sent as 10 bits in this order: a 0, then the eight data bits from bit 0 to bit 7, then a 1.
- R6: After the last character (or after the start-of-frame marker when the count is 0), the stream carries 10 bits of value 0. In tag mode these are followed by exactly 2 bits of value 1, which end the frame.
- R7: In reader mode, the 10 zero bits that close the frame are followed by exactly 32 bits of value 1, which end the frame.
- R8: `byteReady` is high only between characters, and `bitValid` is low whenever it is high. A byte is taken on a cycle in which `byteValid` and `byteReady` are both high, and exactly `frameLen` bytes are taken per frame. While no byte is offered, no bit is offered.
- R9: A frame with `frameLen`=0 never raises `byteReady`. It carries only the opening run, the start-of-frame marker, the closing zeros and the tail.
- R10: A bit is taken only on a cycle with `bitValid` and `bitReady` both high. While `bitValid` is high and `bitReady` is low, both `bitValid` and `bitData` hold their values into the next cycle.
- R11: `done` is high for exactly one cycle per frame, in the cycle right after the last tail bit is taken. A `start` that arrives while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a frame when the encoder is idle |
| readerMode | input | 1 | Framing side, latched at start: 1 selects reader framing, 0 selects tag framing |
| frameLen | input | LEN_W | Number of bytes in the frame, latched at start |
| byteData | input | DATA_W | Offered byte |
| byteValid | input | 1 | `byteData` is valid |
| byteReady | output | 1 | Encoder takes a byte this cycle if one is offered |
| bitData | output | 1 | Current line bit |
| bitValid | output | 1 | `bitData` is valid |
| bitReady | input | 1 | Downstream takes the bit this cycle |
| done | output | 1 | One-cycle pulse after the last tail bit |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that the bit is held stable under backpressure, that a byte request never coincides with an offered bit, and that `done` is a single-cycle pulse. The pulse must come right after a taken bit of value 1, with the bit stream idle. Only the bench scenarios can show the frame layout itself: the run lengths in each mode, the character bit order, the zero-length frame, the exact byte count, and the rejection of a second start partway through a frame. The bench does this by rebuilding each expected frame and comparing it segment by segment.

// File: rtl/fbe_pkg.sv
package fbe_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SOFL,
    PH_SOFH,
    PH_FETCH,
    PH_CHAR,
    PH_EOF,
    PH_TAIL
  } phase_t;

  typedef enum logic [1:0] {
    SEL_ONE,
    SEL_ZERO,
    SEL_DATA
  } bitSel_t;

  typedef struct packed {
    logic    loadByte;
    logic    shiftBit;
    bitSel_t bitSel;
  } dpCtrl_t;

endpackage

// File: rtl/fbe_ctrl.sv
module fbe_ctrl
  import fbe_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int CHAR_BITS = 10,
  parameter int TAG_PRE   = 20,
  parameter int RDR_PRE   = 40,
  parameter int SOF_ZEROS = 10,
  parameter int SOF_ONES  = 2,
  parameter int EOF_ZEROS = 10,
  parameter int TAG_TAIL  = 2,
  parameter int RDR_TAIL  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             readerMode,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             byteValid,
  output logic             byteReady,
  output logic             bitValid,
  input  logic             bitReady,
  output logic             done,
  output dpCtrl_t          strobes
);

  localparam int MAX_A = (TAG_PRE > RDR_PRE) ? TAG_PRE : RDR_PRE;
  localparam int MAX_B = (TAG_TAIL > RDR_TAIL) ? TAG_TAIL : RDR_TAIL;
  localparam int MAX_C = (SOF_ZEROS > EOF_ZEROS) ? SOF_ZEROS : EOF_ZEROS;
  localparam int MAX_D = (CHAR_BITS > SOF_ONES) ? CHAR_BITS : SOF_ONES;
  localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CD = (MAX_C > MAX_D) ? MAX_C : MAX_D;
  localparam int MAX_SEG = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W = $clog2(MAX_SEG + 1);

  phase_t           phase, phaseN;
  logic [CNT_W-1:0] cnt, cntN, segLen;
  logic [LEN_W-1:0] remain, remainN;
  logic             modeQ, modeN;
  logic             bitFire, segLast, lastTail;

  assign bitValid  = (phase != PH_IDLE) && (phase != PH_FETCH);
  assign byteReady = (phase == PH_FETCH);
  assign bitFire   = bitValid && bitReady;
  assign segLast   = (cnt == segLen - CNT_W'(1));

  always_comb begin
    case (phase)
      PH_PRE:  segLen = modeQ ? CNT_W'(RDR_PRE) : CNT_W'(TAG_PRE);
      PH_SOFL: segLen = CNT_W'(SOF_ZEROS);
      PH_SOFH: segLen = CNT_W'(SOF_ONES);
      PH_CHAR: segLen = CNT_W'(CHAR_BITS);
      PH_EOF:  segLen = CNT_W'(EOF_ZEROS);
      PH_TAIL: segLen = modeQ ? CNT_W'(RDR_TAIL) : CNT_W'(TAG_TAIL);
      default: segLen = CNT_W'(1);
    endcase
  end

  always_comb begin
    phaseN   = phase;
    cntN     = cnt;
    remainN  = remain;
    modeN    = modeQ;
    lastTail = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (start) begin
          phaseN  = PH_PRE;
          cntN    = '0;
          remainN = frameLen;
          modeN   = readerMode;
        end
      end
      PH_FETCH: begin
        if (byteValid) begin
          phaseN  = PH_CHAR;
          cntN    = '0;
          remainN = remain - LEN_W'(1);
        end
      end
      default: begin
        if (bitFire) begin
          if (segLast) begin
            cntN = '0;
            case (phase)
              PH_PRE:  phaseN = PH_SOFL;
              PH_SOFL: phaseN = PH_SOFH;
              PH_SOFH,
              PH_CHAR: phaseN = (remain == '0) ? PH_EOF : PH_FETCH;
              PH_EOF:  phaseN = PH_TAIL;
              default: begin
                phaseN   = PH_IDLE;
                lastTail = 1'b1;
              end
            endcase
          end else begin
            cntN = cnt + CNT_W'(1);
          end
        end
      end
    endcase
  end

  always_comb begin
    strobes.loadByte = (phase == PH_FETCH) && byteValid;
    strobes.shiftBit = (phase == PH_CHAR) && bitFire;
    case (phase)
      PH_CHAR:                   strobes.bitSel = SEL_DATA;
      PH_PRE, PH_SOFH, PH_TAIL:  strobes.bitSel = SEL_ONE;
      default:                   strobes.bitSel = SEL_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      remain <= '0;
      modeQ  <= 1'b0;
      done   <= 1'b0;
    end else begin
      phase  <= phaseN;
      cnt    <= cntN;
      remain <= remainN;
      modeQ  <= modeN;
      done   <= lastTail;
    end
  end

endmodule

// File: rtl/fbe_datapath.sv
module fbe_datapath
  import fbe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           strobes,
  input  logic [DATA_W-1:0] byteData,
  output logic              bitData
);

  localparam int CHAR_BITS = DATA_W + 2;

  logic [CHAR_BITS-1:0] charQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      charQ <= '1;
    end else if (strobes.loadByte) begin
      charQ <= {1'b1, byteData, 1'b0};
    end else if (strobes.shiftBit) begin
      charQ <= {1'b1, charQ[CHAR_BITS-1:1]};
    end
  end

  always_comb begin
    case (strobes.bitSel)
      SEL_DATA: bitData = charQ[0];
      SEL_ONE:  bitData = 1'b1;
      default:  bitData = 1'b0;
    endcase
  end

endmodule

// File: rtl/frame_bit_encoder.sv
module frame_bit_encoder
  import fbe_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int DATA_W    = 8,
  parameter int TAG_PRE   = 20,
  parameter int RDR_PRE   = 40,
  parameter int SOF_ZEROS = 10,
  parameter int SOF_ONES  = 2,
  parameter int EOF_ZEROS = 10,
  parameter int TAG_TAIL  = 2,
  parameter int RDR_TAIL  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              readerMode,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteValid,
  output logic              byteReady,
  output logic              bitData,
  output logic              bitValid,
  input  logic              bitReady,
  output logic              done
);

  localparam int CHAR_BITS = DATA_W + 2;

  dpCtrl_t strobes;

  fbe_ctrl #(
    .LEN_W(LEN_W), .CHAR_BITS(CHAR_BITS), .TAG_PRE(TAG_PRE), .RDR_PRE(RDR_PRE),
    .SOF_ZEROS(SOF_ZEROS), .SOF_ONES(SOF_ONES), .EOF_ZEROS(EOF_ZEROS),
    .TAG_TAIL(TAG_TAIL), .RDR_TAIL(RDR_TAIL)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .readerMode(readerMode),
    .frameLen(frameLen), .byteValid(byteValid), .byteReady(byteReady),
    .bitValid(bitValid), .bitReady(bitReady), .done(done), .strobes(strobes)
  );

  fbe_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteData(byteData), .bitData(bitData)
  );

endmodule

// File: rtl/frame_bit_encoder_chk.sv
module frame_bit_encoder_chk (
  input logic clk,
  input logic rstN,
  input logic byteReady,
  input logic bitData,
  input logic bitValid,
  input logic bitReady,
  input logic done
);

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    bitValid && !bitReady |=> bitValid && $stable(bitData)); // R10

  AST_BYTE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    byteReady |-> !bitValid); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_DONE_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(bitValid && bitReady && bitData)); // R11

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !bitValid && !byteReady); // R11

endmodule

bind frame_bit_encoder frame_bit_encoder_chk chk_i (
  .clk(clk), .rstN(rstN), .byteReady(byteReady), .bitData(bitData),
  .bitValid(bitValid), .bitReady(bitReady), .done(done)
);

// File: tb/frame_bit_encoder_tb.sv
module frame_bit_encoder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       readerMode = 1'b0;
  logic [7:0] frameLen = '0;
  logic [7:0] byteData = '0;
  logic       byteValid = 1'b0;
  logic       byteReady;
  logic       bitData;
  logic       bitValid;
  logic       bitReady = 1'b0;
  logic       done;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_bit_encoder dut_i (
    .clk(clk), .rstN(rstN), .start(start), .readerMode(readerMode),
    .frameLen(frameLen), .byteData(byteData), .byteValid(byteValid),
    .byteReady(byteReady), .bitData(bitData), .bitValid(bitValid),
    .bitReady(bitReady), .done(done)
  );

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit finished = 0;

  bit expBits[$];
  bit gotBits[$];
  logic [7:0] payload[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      summary();
    end
  end

  function automatic void pushRun(bit v, int n);
    for (int i = 0; i < n; i++) expBits.push_back(v);
  endfunction

  function automatic int segErr(int a, int b);
    int e = 0;
    for (int i = a; i < b; i++) begin
      if (i >= gotBits.size()) e++;
      else if (gotBits[i] != expBits[i]) e++;
    end
    return e;
  endfunction

  task automatic runFrame(bit rdr, int n, int readyPct, int bytePct, bit poke);
    int preN, tailN, sofEnd, charEnd, eofEnd, total;
    int bidx, cyc, lastFire, doneCnt, doneCyc, gapErr, holdErr, readyEmpty, after;
    bit stallPrev, stallBit, seenDone;
    string preReq, tailReq;
    payload.delete();
    expBits.delete();
    gotBits.delete();
    for (int i = 0; i < n; i++) begin
      if (n == 1) payload.push_back(8'h80);
      else if (i == 0) payload.push_back(8'h00);
      else if (i == 1) payload.push_back(8'hFF);
      else payload.push_back(8'($urandom));
    end
    preN  = rdr ? 40 : 20;
    tailN = rdr ? 32 : 2;
    pushRun(1'b1, preN);
    pushRun(1'b0, 10);
    pushRun(1'b1, 2);
    for (int i = 0; i < n; i++) begin
      expBits.push_back(1'b0);
      for (int k = 0; k < 8; k++) expBits.push_back(payload[i][k]);
      expBits.push_back(1'b1);
    end
    pushRun(1'b0, 10);
    pushRun(1'b1, tailN);
    sofEnd  = preN + 12;
    charEnd = sofEnd + 10 * n;
    eofEnd  = charEnd + 10;
    total   = eofEnd + tailN;

    @(negedge clk);
    start = 1'b1;
    readerMode = rdr;
    frameLen = 8'(n);
    byteValid = 1'b0;
    bitReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    bidx = 0; cyc = 0; lastFire = -1; doneCnt = 0; doneCyc = -1;
    gapErr = 0; holdErr = 0; readyEmpty = 0; after = 0;
    stallPrev = 0; stallBit = 0; seenDone = 0;
    while (cyc < 20000 && after < 3) begin
      if (cyc > 0) @(negedge clk);
      bitReady = (($urandom % 100) < 32'(readyPct));
      byteValid = (bidx < n) && (($urandom % 100) < 32'(bytePct));
      byteData = (bidx < n) ? payload[bidx] : 8'h5A;
      if (poke && (cyc == 30 || cyc == 31)) begin
        start = 1'b1;
        readerMode = !rdr;
        frameLen = 8'(n + 2);
      end else begin
        start = 1'b0;
      end
      #1;
      if (byteReady && bitValid) gapErr++;
      if (stallPrev && (!bitValid || bitData != stallBit)) holdErr++;
      stallPrev = bitValid && !bitReady;
      stallBit = bitData;
      if (bitValid && bitReady) begin
        gotBits.push_back(bitData);
        lastFire = cyc;
      end
      if (byteReady && n == 0) readyEmpty++;
      if (byteReady && byteValid) bidx++;
      if (done) begin
        doneCnt++;
        if (doneCyc < 0) doneCyc = cyc;
        seenDone = 1;
      end
      if (seenDone) after++;
      cyc++;
    end
    start = 1'b0;
    bitReady = 1'b0;
    byteValid = 1'b0;

    preReq  = rdr ? "R3" : "R2";
    tailReq = rdr ? "R7" : "R6";
    check(gotBits.size() == total, preReq, "frame bit count", gotBits.size(), total);
    check(segErr(0, preN) == 0, preReq, "opening run mismatches", segErr(0, preN), 0);
    check(segErr(preN, sofEnd) == 0, "R4", "start marker mismatches", segErr(preN, sofEnd), 0);
    check(segErr(sofEnd, charEnd) == 0, "R5", "character mismatches", segErr(sofEnd, charEnd), 0);
    check(segErr(charEnd, eofEnd) == 0, "R6", "end marker mismatches", segErr(charEnd, eofEnd), 0);
    check(segErr(eofEnd, total) == 0, tailReq, "tail mismatches", segErr(eofEnd, total), 0);
    check(doneCnt == 1, "R11", "done pulses", doneCnt, 1);
    check(doneCyc == lastFire + 1, "R11", "done cycle", doneCyc, lastFire + 1);
    check(gapErr == 0, "R8", "byteReady with bitValid", gapErr, 0);
    check(bidx == n, "R8", "bytes taken", bidx, n);
    check(holdErr == 0, "R10", "hold violations", holdErr, 0);
    if (n == 0) check(readyEmpty == 0, "R9", "byteReady on empty frame", readyEmpty, 0);
    if (poke) check(gotBits.size() == total, "R11", "bits after ignored start", gotBits.size(), total);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!bitValid && !byteReady && !done, "R1", "outputs in reset",
          {bitValid, byteReady, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!bitValid && !byteReady && !done, "R1", "outputs after reset",
          {bitValid, byteReady, done}, 0);

    runFrame(1'b0, 0, 100, 100, 1'b0);  // R9 tag, empty
    runFrame(1'b1, 0, 100, 100, 1'b0);  // R9 reader, empty
    runFrame(1'b0, 1, 100, 100, 1'b0);  // R5 single byte
    runFrame(1'b1, 3, 70, 60, 1'b0);
    runFrame(1'b0, 5, 50, 40, 1'b0);
    runFrame(1'b1, 8, 30, 80, 1'b0);    // R10 heavy backpressure
    runFrame(1'b0, 2, 100, 100, 1'b1);  // R11 start ignored mid-frame
    runFrame(1'b1, 2, 100, 100, 1'b1);
    for (int f = 0; f < 4; f++) begin
      runFrame(1'($urandom), int'($urandom % 7), 40 + int'($urandom % 60),
               30 + int'($urandom % 70), 1'b0);
    end
    summary();
  end

endmodule